// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral watches for a stalled processor with a down counter. Software sets a load value and then turns on the run bit. From then on the counter counts down once per clock. When it reaches zero the first time, the block flags a timeout, raises an interrupt and reloads. If software has not cleared the flag by the next zero, the block escalates. When reset escalation is enabled, it issues a one-cycle system reset request. The timeout can be routed to the ordinary interrupt line or to the non-maskable line.

Configuration is guarded by a write lock. Any write to the lock register other than the unlock key freezes the control, load and test registers. The key opens them again. A test bit can freeze the count while an external debug-halt input is high. Software reaches the block through a plain synchronous register bus. A write takes effect on the clock edge where `bus_sel` and `bus_we` are both high. Reads are combinational from `bus_addr`. The bus has no back-pressure: every access completes in its own cycle.

Top module: `dual_stage_watchdog`

## Requirements
- R1: After reset, all three outputs are low, the control register reads 0, the lock register reads 0 and the count register holds the reset load value.
- R2: The control register has three fields: bit 0 is the run bit, bit 1 enables reset escalation and bit 2 selects the non-maskable route. Setting the run bit starts the count, which begins from the load value and drops by one each cycle. Reading the control register shows the run bit. Once set, the run bit stays set until hardware reset, even if software writes 0 to it.
- R3: When a running count is at zero, the next edge sets raw status bit 0 and reloads the count from the load register. A load value L therefore gives L+1 cycles per period.
- R4: If the count reaches zero again while raw status is still set and reset escalation is enabled, the reset request goes high for exactly one cycle. With escalation disabled, it stays low.
- R5: A load write copies the written value into the count on the same edge.
- R6: Writing a load value of 0 sets raw status on that edge, whether or not the run bit is set.
- R7: Writing any value other than the key 0x1ACCE551 to the lock register locks the block, and the lock register then reads 1. While locked, writes to the control, load and test registers have no effect. Writing the key unlocks the block, and the lock register then reads 0.
- R8: The pending timeout drives the interrupt output when bit 2 is 0, or the non-maskable output when bit 2 is 1. It drives an output only while the run bit is set, and never drives both outputs at once.
- R9: Writing a 1 in bit 0 of the clear register clears raw status. Masked status is raw status ANDed with the run bit.
- R10: When stall bit 0 of the test register is set, the count holds while the debug-halt input is high. When the stall bit is clear, the debug-halt input has no effect.
- R11: While locked, the clear, status, count and lock registers still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte offset: load 0x00, count 0x04, control 0x08, clear 0x0C, raw 0x10, masked 0x14, test 0x18, lock 0x1C |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dbg_halt | input | 1 | Debug halt from the processor |
| irq_o | output | 1 | Normal timeout interrupt |
| nmi_o | output | 1 | Non-maskable timeout interrupt |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench uses random load values and measures the exact cycle of each timeout. A design that is off by one in the zero-and-reload step would move both the interrupt and the reset by a cycle. Scenarios with and without a status clear check that escalation happens only when the flag is left set. A design that ignored the pending flag would reset on the first timeout, or fail to reset at all.

Directed cases cover the locked writes, the sticky run bit, a zero load while idle and the debug stall. Each of these is observed through readback or at the outputs. A lock that missed a register, or a stall that leaked, would show up as a changed readback value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_LOAD  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_VALUE = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CTL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_MSK   = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_TEST  = 5'h18;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 5'h1C;

  localparam logic [DATA_W-1:0] OPEN_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic nmi_sel;
    logic esc_en;
    logic run;
  } ctl_t;
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output ctl_t              ctl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic              stall_q,
  output logic              locked_q,
  output logic              load_wr
);
  logic wr;
  assign wr      = bus_sel && bus_we;
  assign load_wr = wr && (bus_addr == OFF_LOAD) && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      load_q   <= LOAD_RST;
      stall_q  <= 1'b0;
      locked_q <= 1'b0;
    end else if (wr) begin
      case (bus_addr)
        OFF_LOCK: locked_q <= (bus_wdata != OPEN_KEY);
        OFF_CTL: if (!locked_q) begin
          ctl_q.run     <= ctl_q.run | bus_wdata[0];
          ctl_q.esc_en  <= bus_wdata[1];
          ctl_q.nmi_sel <= bus_wdata[2];
        end
        OFF_LOAD: if (!locked_q) load_q  <= bus_wdata[CNT_W-1:0];
        OFF_TEST: if (!locked_q) stall_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count_q,
  output logic             zero_tick
);
  assign zero_tick = run && !hold && !load_wr && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_q <= LOAD_RST;
    else if (load_wr)          count_q <= load_val;
    else if (!run)             count_q <= load_q;
    else if (hold)             count_q <= count_q;
    else if (count_q == '0)    count_q <= load_q;
    else                       count_q <= count_q - 1'b1;
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_tick,
  input  logic load_zero,
  input  logic clr_req,
  input  logic run,
  input  logic esc_en,
  input  logic nmi_sel,
  output logic status_q,
  output logic rst_req_q,
  output logic irq,
  output logic nmi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= zero_tick && status_q && esc_en;
      if (zero_tick || load_zero) status_q <= 1'b1;
      else if (clr_req)           status_q <= 1'b0;
    end
  end

  assign irq = status_q && run && !nmi_sel;
  assign nmi = status_q && run && nmi_sel;
endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              sys_rst_req_o
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] count_q;
  logic             stall_q, locked_q, load_wr, zero_tick, status_q, hold, clr_req;

  wdt_cfg #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctl_q(ctl_q),
    .load_q(load_q), .stall_q(stall_q), .locked_q(locked_q), .load_wr(load_wr)
  );

  assign hold = stall_q && dbg_halt;

  wdt_count #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .hold(hold),
    .load_wr(load_wr), .load_val(bus_wdata[CNT_W-1:0]), .load_q(load_q),
    .count_q(count_q), .zero_tick(zero_tick)
  );

  assign clr_req = bus_sel && bus_we && (bus_addr == OFF_CLR) && bus_wdata[0];

  wdt_event u_evt (
    .clk(clk), .rst_n(rst_n), .zero_tick(zero_tick),
    .load_zero(load_wr && (bus_wdata[CNT_W-1:0] == '0)),
    .clr_req(clr_req), .run(ctl_q.run), .esc_en(ctl_q.esc_en),
    .nmi_sel(ctl_q.nmi_sel), .status_q(status_q), .rst_req_q(sys_rst_req_o),
    .irq(irq_o), .nmi(nmi_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_LOAD:  bus_rdata[CNT_W-1:0] = load_q;
      OFF_VALUE: bus_rdata[CNT_W-1:0] = count_q;
      OFF_CTL:   bus_rdata[2:0] = ctl_q;
      OFF_RAW:   bus_rdata[0] = status_q;
      OFF_MSK:   bus_rdata[0] = status_q && ctl_q.run;
      OFF_TEST:  bus_rdata[0] = stall_q;
      OFF_LOCK:  bus_rdata[0] = locked_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              dbg_halt,
  input logic              irq_o,
  input logic              nmi_o,
  input logic              sys_rst_req_o,
  input logic              run,
  input logic              stall,
  input logic              locked,
  input logic              status,
  input logic [2:0]        ctl_bits,
  input logic [CNT_W-1:0]  count
);
  // R4
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |=> !sys_rst_req_o);
  // R4
  rst_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req_o) |-> $past(status));
  // R8
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && nmi_o));
  // R2
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);
  // R7
  lock_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_sel && bus_we && bus_addr == OFF_CTL) |=> $stable(ctl_bits));
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stall && dbg_halt && !(bus_sel && bus_we && bus_addr == OFF_LOAD))
      |=> $stable(count));
endmodule

bind dual_stage_watchdog wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .dbg_halt(dbg_halt), .irq_o(irq_o), .nmi_o(nmi_o),
  .sys_rst_req_o(sys_rst_req_o), .run(ctl_q.run), .stall(stall_q),
  .locked(locked_q), .status(status_q), .ctl_bits(ctl_q), .count(count_q)
);

// File: tb/dual_stage_watchdog_tb.sv
`timescale 1ns/1ps
module dual_stage_watchdog_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0, dbg_halt = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq_o, nmi_o, sys_rst_req_o;
  int          n_chk = 0, n_err = 0;

  localparam logic [4:0] A_LOAD = 5'h00, A_VAL = 5'h04, A_CTL = 5'h08,
    A_CLR = 5'h0C, A_RAW = 5'h10, A_MSK = 5'h14, A_TEST = 5'h18, A_LOCK = 5'h1C;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  always #5 clk = ~clk;

  dual_stage_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .irq_o(irq_o), .nmi_o(nmi_o),
    .sys_rst_req_o(sys_rst_req_o)
  );

  function automatic logic [31:0] ctl_word(bit run, bit esc, bit nmi);
    return {29'b0, nmi, esc, run};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; dbg_halt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_period(int lv, bit esc, bit clr);
    logic [31:0] r;
    do_reset();
    wr(A_LOAD, lv);
    wr(A_CTL, ctl_word(1, esc, 0));
    rd(A_VAL, r); check("R2 start value", r, lv);
    repeat (lv) @(negedge clk);
    rd(A_RAW, r); check("R3 no early flag", r, 0);
    rd(A_VAL, r); check("R2 count at zero", r, 0);
    @(negedge clk);
    rd(A_RAW, r); check("R3 flag at timeout", r, 1);
    rd(A_VAL, r); check("R3 reload", r, lv);
    check("R8 irq on timeout", irq_o, 1);
    if (clr) begin
      wr(A_CLR, 1);
      rd(A_RAW, r); check("R9 clear", r, 0);
      repeat (lv) @(negedge clk);
      check("R4 no reset after clear", sys_rst_req_o, 0);
      rd(A_RAW, r); check("R3 second flag", r, 1);
    end else begin
      repeat (lv) @(negedge clk);
      check("R4 no reset early", sys_rst_req_o, 0);
      @(negedge clk);
      check("R4 escalation", sys_rst_req_o, esc);
      @(negedge clk);
      check("R4 single cycle", sys_rst_req_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1-all: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    check("R1 irq", irq_o, 0);
    check("R1 nmi", nmi_o, 0);
    check("R1 rst", sys_rst_req_o, 0);
    rd(A_CTL, r);  check("R1 ctl", r, 0);
    rd(A_LOCK, r); check("R1 lock", r, 0);
    rd(A_VAL, r);  check("R1 value", r, 32'hFFFF_FFFF);

    for (int i = 0; i < 8; i++)
      run_period($urandom_range(2, 20), $urandom_range(0, 1), i[0]);
    run_period(7, 1, 0);

    // R5 reload on load write while running
    do_reset();
    wr(A_LOAD, 50);
    wr(A_CTL, ctl_word(1, 0, 0));
    repeat (10) @(negedge clk);
    wr(A_LOAD, 5);
    rd(A_VAL, r); check("R5 immediate copy", r, 5);
    repeat (5) @(negedge clk);
    rd(A_RAW, r); check("R5 no flag yet", r, 0);
    @(negedge clk);
    rd(A_RAW, r); check("R5 flag after new load", r, 1);

    // R8 non-maskable route
    do_reset();
    wr(A_LOAD, 3);
    wr(A_CTL, ctl_word(1, 0, 1));
    repeat (4) @(negedge clk);
    check("R8 nmi high", nmi_o, 1);
    check("R8 irq low", irq_o, 0);

    // R6 and R9: zero load while idle, masked view
    do_reset();
    wr(A_LOAD, 0);
    rd(A_RAW, r); check("R6 flag on zero load", r, 1);
    rd(A_MSK, r); check("R9 masked while idle", r, 0);
    check("R8 no irq while idle", irq_o, 0);
    wr(A_CTL, ctl_word(1, 0, 0));
    rd(A_MSK, r); check("R9 masked when running", r, 1);
    check("R8 irq when running", irq_o, 1);

    // R7, R11 lock behaviour; R2 sticky run bit
    do_reset();
    wr(A_LOAD, 10);
    wr(A_LOCK, 0);
    rd(A_LOCK, r); check("R7 locked reads 1", r, 1);
    wr(A_LOAD, 99);
    rd(A_LOAD, r); check("R7 load blocked", r, 10);
    wr(A_CTL, ctl_word(1, 1, 1));
    rd(A_CTL, r); check("R7 ctl blocked", r, 0);
    wr(A_TEST, 1);
    rd(A_TEST, r); check("R7 test blocked", r, 0);
    wr(A_LOAD, 0);
    rd(A_RAW, r); check("R7 zero load blocked", r, 0);
    rd(A_VAL, r); check("R11 value readable", r, 10);
    wr(A_LOCK, KEY);
    rd(A_LOCK, r); check("R7 key unlocks", r, 0);
    wr(A_LOAD, 0);
    rd(A_RAW, r); check("R6 flag set", r, 1);
    wr(A_LOCK, 32'hDEAD_BEEF);
    wr(A_CLR, 1);
    rd(A_RAW, r); check("R11 clear while locked", r, 0);
    wr(A_LOCK, KEY);
    wr(A_LOAD, 40);
    wr(A_CTL, ctl_word(1, 0, 0));
    wr(A_CTL, ctl_word(0, 0, 0));
    rd(A_CTL, r); check("R2 run bit sticky", r, 1);

    // R10 stall
    do_reset();
    wr(A_LOAD, 30);
    dbg_halt = 1;
    wr(A_CTL, ctl_word(1, 0, 0));
    repeat (5) @(negedge clk);
    rd(A_VAL, r); check("R10 halt ignored without stall", r, 25);
    wr(A_TEST, 1);
    rd(A_VAL, r); check("R10 stall write edge", r, 24);
    repeat (6) @(negedge clk);
    rd(A_VAL, r); check("R10 held", r, 24);
    dbg_halt = 0;
    repeat (4) @(negedge clk);
    rd(A_VAL, r); check("R10 resumes", r, 20);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule